// File: doc/BRIEF.md
# Processor Presence Bitmap with Hot-Add Event

This block holds one presence bit per processor slot and lets the host read the whole set one byte at a time. Platform logic reports processors arriving or leaving through two request channels, a plug channel and an unplug channel. Each carries a valid strobe and a processor number. An accepted request edits exactly one bit of the bitmap. It also pulses the status bit that the general-purpose event block uses for processor changes, so that the host's event logic looks at the interrupt again.

At reset the bitmap takes a boot vector, so processors present at power-on are marked without any event. The host side is a single-byte port. A read returns the addressed byte on the next clock. A write is accepted on the same port and changes nothing. A processor number that falls past the end of the bitmap is dropped. It raises an error flag that stays high until the next reset.

Top module: `cpu_presence_map`

## Requirements
- R1: The bitmap has NUM_BYTES bytes (default 32). Processor number n lives at bit (n mod 8) of byte (n div 8), so host byte k holds processors 8k (bit 0) through 8k+7 (bit 7).
- R2: A host read (host_vld=1, host_we=0) drives the addressed byte on rd_data one clock later. rd_data holds its value in cycles without a read, and it is 0 after reset.
- R3: While rst_n is low, the bitmap loads boot_mask, with bit n of boot_mask giving processor n.
- R4: An accepted plug request sets the bit of its processor number.
- R5: An accepted unplug request clears the bit of its processor number.
- R6: A plug and an unplug in the same cycle are both applied. If they name the same processor, the bit ends set.
- R7: Each cycle holding at least one accepted request produces gpe_sts_set = 8'h04 (bit 2 only) during the next cycle. Otherwise gpe_sts_set is 0, including after reset.
- R8: A host write (host_vld=1, host_we=1) changes neither the bitmap nor rd_data.
- R9: A request whose processor number is NUM_BYTES*8 or more is dropped. It changes no bit and produces no event pulse. It sets id_err one clock later, and id_err stays set until reset, which clears it.
- R10: A read in the same cycle as a plug or unplug returns the byte as it was before that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the boot vector |
| boot_mask | input | NUM_BYTES*8 | Processors present at power-on |
| plug_vld | input | 1 | Plug request strobe |
| plug_id | input | ID_W | Processor number of the plug request |
| unplug_vld | input | 1 | Unplug request strobe |
| unplug_id | input | ID_W | Processor number of the unplug request |
| host_vld | input | 1 | Host byte access strobe |
| host_we | input | 1 | Host access is a write (ignored) |
| host_addr | input | $clog2(NUM_BYTES) | Host byte index |
| host_wdata | input | 8 | Host write data (ignored) |
| rd_data | output | 8 | Registered read byte |
| gpe_sts_set | output | GPE_W | One-cycle set pulse for the event status bits; only bit 2 is used |
| id_err | output | 1 | Sticky flag for an out-of-range processor number |

## Verification
A wrong bitmap bit stays hidden until the host reads the byte that holds it. The first read after the fault shows it one clock later, so the bench reads each edited byte right after the request and sweeps the whole window at the end. A wrong event or error decision shows on gpe_sts_set or id_err in the very next cycle, and both are compared after every request cycle. Reads issued in the same cycle as an update, and writes, test the ordering and the no-effect rules through rd_data.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
    // Status bit in the general-purpose event block used for processor changes.
    localparam int unsigned GPE_CPU_BIT = 2;
    localparam int unsigned BYTE_W      = 8;
    // Request channel order inside the decoder array.
    localparam int unsigned REQ_PLUG    = 0;
    localparam int unsigned REQ_UNPLUG  = 1;
    localparam int unsigned NUM_REQ     = 2;
endpackage

// File: rtl/cpuhp_req_decode.sv
module cpuhp_req_decode #(
    parameter int unsigned ID_W  = 8,
    parameter int unsigned NBITS = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [ID_W-1:0]  req_id,
    output logic [NBITS-1:0] req_mask,
    output logic             req_bad
);
    localparam int unsigned CMP_W = ID_W + 1;
    localparam logic [CMP_W-1:0] LIMIT = CMP_W'(NBITS);

    logic in_range;

    always_comb begin
        in_range = ({1'b0, req_id} < LIMIT);
        req_mask = '0;
        if (req_vld && in_range) begin
            req_mask = NBITS'(1) << req_id;
        end
        req_bad = req_vld && !in_range;
    end

    // R4 R5: a decoded request touches at most one bit
    assert_mask_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_mask));
    // R9: a rejected request never produces a bit edit
    assert_bad_no_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_bad |-> (req_mask == '0));
endmodule

// File: rtl/cpuhp_map.sv
module cpuhp_map
    import cpuhp_pkg::*;
#(
    parameter int unsigned NBITS = 256,
    parameter int unsigned GPE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] boot_mask,
    input  logic [NBITS-1:0] set_mask,
    input  logic [NBITS-1:0] clr_mask,
    input  logic             bad_any,
    output logic [NBITS-1:0] map_q,
    output logic [GPE_W-1:0] gpe_set_q,
    output logic             err_q
);
    typedef struct packed {
        logic [NBITS-1:0] map;
        logic [GPE_W-1:0] gpe;
        logic             err;
    } map_state_t;

    map_state_t st_d, st_q;
    logic       any_evt;

    always_comb begin
        st_d    = st_q;
        any_evt = (set_mask != '0) || (clr_mask != '0);
        // Clear first so that a plug of the same processor wins.
        st_d.map = (st_q.map & ~clr_mask) | set_mask;
        st_d.gpe = '0;
        if (any_evt) begin
            st_d.gpe[GPE_CPU_BIT] = 1'b1;
        end
        st_d.err = st_q.err | bad_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.map <= boot_mask;
            st_q.gpe <= '0;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_q     = st_q.map;
    assign gpe_set_q = st_q.gpe;
    assign err_q     = st_q.err;

    assert_plug_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((map_q & $past(set_mask)) == $past(set_mask)));
    assert_unplug_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~set_mask) != '0) |=> ((map_q & $past(clr_mask & ~set_mask)) == '0));
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask == '0) && (clr_mask == '0)) |=> $stable(map_q));
    assert_evt_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask != '0) || (clr_mask != '0)) |=> ($countones(gpe_set_q) == 1));
    assert_no_evt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask == '0) && (clr_mask == '0)) |=> (gpe_set_q == '0));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_err_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_any |=> err_q);
endmodule

// File: rtl/cpuhp_rdport.sv
module cpuhp_rdport
    import cpuhp_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 32,
    parameter int unsigned AW        = $clog2(NUM_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_vld,
    input  logic                      host_we,
    input  logic [AW-1:0]             host_addr,
    input  logic [BYTE_W-1:0]         host_wdata,
    input  logic [NUM_BYTES*BYTE_W-1:0] map,
    output logic [BYTE_W-1:0]         rd_data
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
    } rd_state_t;

    rd_state_t        rd_d, rd_q;
    logic [BYTE_W-1:0] win_byte [NUM_BYTES];
    logic [BYTE_W-1:0] sel_byte;
    logic              rd_req;
    logic              unused_wdata;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        assign win_byte[b] = map[b*BYTE_W +: BYTE_W];
    end

    // Write data is accepted on the port and discarded.
    assign unused_wdata = ^host_wdata;

    always_comb begin
        rd_d     = rd_q;
        rd_req   = host_vld && !host_we;
        sel_byte = '0;
        if (32'(host_addr) < NUM_BYTES) begin
            sel_byte = win_byte[host_addr];
        end
        if (rd_req) begin
            rd_d.data = sel_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q.data;

    assert_write_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_vld && host_we) |=> $stable(rd_data));
    assert_hold_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_vld |=> $stable(rd_data));
endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map
    import cpuhp_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 32,
    parameter int unsigned ID_W      = 8,
    parameter int unsigned GPE_W     = 8,
    localparam int unsigned NBITS    = NUM_BYTES * BYTE_W,
    localparam int unsigned AW       = $clog2(NUM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBITS-1:0]  boot_mask,
    input  logic              plug_vld,
    input  logic [ID_W-1:0]   plug_id,
    input  logic              unplug_vld,
    input  logic [ID_W-1:0]   unplug_id,
    input  logic              host_vld,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] rd_data,
    output logic [GPE_W-1:0]  gpe_sts_set,
    output logic              id_err
);
    logic             req_vld  [NUM_REQ];
    logic [ID_W-1:0]  req_id   [NUM_REQ];
    logic [NBITS-1:0] req_mask [NUM_REQ];
    logic             req_bad  [NUM_REQ];
    logic [NBITS-1:0] map_q;
    logic             bad_any;

    assign req_vld[REQ_PLUG]   = plug_vld;
    assign req_id[REQ_PLUG]    = plug_id;
    assign req_vld[REQ_UNPLUG] = unplug_vld;
    assign req_id[REQ_UNPLUG]  = unplug_id;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        cpuhp_req_decode #(
            .ID_W  (ID_W),
            .NBITS (NBITS)
        ) u_dec (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_vld  (req_vld[r]),
            .req_id   (req_id[r]),
            .req_mask (req_mask[r]),
            .req_bad  (req_bad[r])
        );
    end

    assign bad_any = req_bad[REQ_PLUG] | req_bad[REQ_UNPLUG];

    cpuhp_map #(
        .NBITS (NBITS),
        .GPE_W (GPE_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mask (boot_mask),
        .set_mask  (req_mask[REQ_PLUG]),
        .clr_mask  (req_mask[REQ_UNPLUG]),
        .bad_any   (bad_any),
        .map_q     (map_q),
        .gpe_set_q (gpe_sts_set),
        .err_q     (id_err)
    );

    cpuhp_rdport #(
        .NUM_BYTES (NUM_BYTES),
        .AW        (AW)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_vld   (host_vld),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .map        (map_q),
        .rd_data    (rd_data)
    );

    // R6: simultaneous plug and unplug of one processor leaves it present
    assert_same_id_plug_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_vld && unplug_vld && (plug_id == unplug_id) && (req_mask[REQ_PLUG] != '0))
        |=> ((map_q & $past(req_mask[REQ_PLUG])) != '0));
endmodule

// File: tb/tb_cpu_presence_map.sv
`timescale 1ns/1ps
module tb_cpu_presence_map;
    localparam int NUM_BYTES = 32;
    localparam int ID_W      = 9;
    localparam int NBITS     = NUM_BYTES * 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NBITS-1:0] boot_mask;
    logic             plug_vld, unplug_vld;
    logic [ID_W-1:0]  plug_id, unplug_id;
    logic             host_vld, host_we;
    logic [4:0]       host_addr;
    logic [7:0]       host_wdata;
    logic [7:0]       rd_data;
    logic [7:0]       gpe_sts_set;
    logic             id_err;

    always #4 clk = ~clk;

    cpu_presence_map #(.NUM_BYTES(NUM_BYTES), .ID_W(ID_W), .GPE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .boot_mask(boot_mask),
        .plug_vld(plug_vld), .plug_id(plug_id),
        .unplug_vld(unplug_vld), .unplug_id(unplug_id),
        .host_vld(host_vld), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .rd_data(rd_data),
        .gpe_sts_set(gpe_sts_set), .id_err(id_err)
    );

    int               n_checks = 0;
    int               n_fail   = 0;
    logic [NBITS-1:0] model;
    logic             err_model;
    logic [7:0]       exp_q [$];
    string            tag_q [$];
    logic             rd_seen = 1'b0;
    logic [7:0]       last_rd;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: a read seen at a rising edge is compared at the next falling edge.
    always @(posedge clk) rd_seen <= rst_n && host_vld && !host_we;

    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, 32'(rd_data), 32'(e));
        end
    end

    // Driver primitives: set inputs at a falling edge, then tick.
    task automatic set_plug(input int id);
        plug_vld = 1'b1; plug_id = ID_W'(id);
    endtask
    task automatic set_unplug(input int id);
        unplug_vld = 1'b1; unplug_id = ID_W'(id);
    endtask
    task automatic set_read(input int addr, input string tag);
        host_vld = 1'b1; host_we = 1'b0; host_addr = 5'(addr);
        exp_q.push_back(model[addr*8 +: 8]);
        tag_q.push_back(tag);
    endtask

    task automatic tick();
        bit pok, uok, acc;
        pok = plug_vld && (int'(plug_id) < NBITS);
        uok = unplug_vld && (int'(unplug_id) < NBITS);
        acc = pok || uok;
        if ((plug_vld && !pok) || (unplug_vld && !uok)) err_model = 1'b1;
        @(negedge clk);
        if (uok) model[int'(unplug_id)] = 1'b0;
        if (pok) model[int'(plug_id)] = 1'b1;
        check(gpe_sts_set === (acc ? 8'h04 : 8'h00), "R7 event pulse",
              32'(gpe_sts_set), acc ? 32'h4 : 32'h0);
        check(id_err === err_model, "R9 error flag", 32'(id_err), 32'(err_model));
        plug_vld = 1'b0; unplug_vld = 1'b0; host_vld = 1'b0; host_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        plug_vld = 1'b0; unplug_vld = 1'b0; plug_id = '0; unplug_id = '0;
        host_vld = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = boot_mask;
        err_model = 1'b0;
        check(rd_data === 8'h00, "R2 reset read data", 32'(rd_data), 0);
        check(gpe_sts_set === 8'h00, "R7 reset event", 32'(gpe_sts_set), 0);
        check(id_err === 1'b0, "R9 reset error flag", 32'(id_err), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        boot_mask = (NBITS'(1) << 200) | NBITS'(7);
        @(negedge clk);
        do_reset();

        // R3: boot vector visible; R1 mapping of id 200 to byte 25 bit 0
        set_read(0, "R3 boot byte 0"); tick();
        set_read(25, "R1 R3 boot byte 25"); tick();

        // R4 plug, R1 byte/bit mapping
        set_plug(9); tick();
        set_read(1, "R4 R1 plug id 9"); tick();
        set_plug(255); tick();
        set_read(31, "R4 R1 plug id 255"); tick();

        // R5 unplug
        set_unplug(1); tick();
        set_read(0, "R5 unplug id 1"); tick();

        // R6 same-cycle requests
        set_plug(40); set_unplug(40); tick();
        set_read(5, "R6 same id plug wins"); tick();
        set_plug(41); set_unplug(0); tick();
        set_read(5, "R6 both applied, plug 41"); tick();
        set_read(0, "R6 both applied, unplug 0"); tick();

        // R10 read alongside an update returns the old byte
        set_read(6, "R10 read with plug"); set_plug(50); tick();
        set_read(6, "R10 byte after plug"); tick();
        set_read(25, "R10 read with unplug"); set_unplug(200); tick();
        set_read(25, "R10 byte after unplug"); tick();

        // R8 host write ignored
        @(negedge clk);
        last_rd = rd_data;
        host_vld = 1'b1; host_we = 1'b1; host_addr = 5'd6; host_wdata = 8'h00; tick();
        check(rd_data === last_rd, "R8 write leaves rd_data", 32'(rd_data), 32'(last_rd));
        set_read(6, "R8 byte unchanged by write"); tick();

        // R2 hold when idle
        last_rd = rd_data;
        tick(); tick();
        check(rd_data === last_rd, "R2 hold without read", 32'(rd_data), 32'(last_rd));

        // R9 out-of-range requests
        set_plug(300); tick();
        set_unplug(256); tick();
        tick();
        set_plug(511); set_unplug(2); tick();
        set_read(0, "R9 valid unplug beside bad plug"); tick();

        // R1 full window sweep
        for (int b = 0; b < NUM_BYTES; b++) begin
            set_read(b, "R1 window sweep"); tick();
        end
        tick(); tick();

        // R9 reset clears the flag, R3 reloads the boot vector
        do_reset();
        set_read(1, "R3 reload after reset"); tick();
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule